// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block is the digital sequencer behind a pair of regulator channels that track one shared reference. Once both bias-supply ready flags are present and no shutdown is requested, it enables the gate drivers. It holds the reference code at zero for a few slow step ticks, then raises the code by a fixed increment on each step tick until the final code is reached. That last step signals that soft-start is complete.

Both channels are monitored by undervoltage comparators. A flag from either channel, once sensing has been unmasked partway into the ramp, turns both channels off and raises a fault. The block then runs a hiccup sequence: three soft-start periods in which the reference sweeps but the drivers stay off, followed by a fourth period that really starts the outputs. If the undervoltage is still present after that ramp has passed its unmask point, the sequence repeats for as long as the fault persists. A held shutdown request or the loss of either ready flag forces everything off. Removing that cause starts a fresh soft-start.

Top module: `ssh_top`

## Requirements
- R1: During reset `ref_code` is 0 and `drv_en`, `ss_done` and `fault` are all 0.
- R2: The block leaves the off state only while both ready flags are 1 and the shutdown request is 0. With only one ready flag, step ticks have no effect. When either ready flag falls, the block returns to off: `ref_code` 0, `drv_en` 0, `ss_done` 0 and `fault` 0.
- R3: When a start begins, `drv_en` rises and `ref_code` stays 0 for INIT_TICKS step ticks (default 3). The first increment comes on the next tick after those.
- R4: In a ramp, each step tick adds STEP_INC (default 4) to `ref_code`. After STEP_COUNT steps (default 27) the code holds at STEP_COUNT*STEP_INC (default 108) and never exceeds it.
- R5: `ss_done` becomes 1 in the cycle in which a driver-enabled ramp reaches the final code. A shutdown, a fault or the loss of a ready flag clears it.
- R6: An undervoltage flag on either channel, when sensing is unmasked, makes the block do the following on the next clock: set `fault` to 1, clear `drv_en`, `ss_done` and `ref_code`, and enter the initialization phase of the first blank cycle.
- R7: Undervoltage flags are ignored in these cases: during initialization, while fewer than UNMASK_STEP (default 7) steps of a ramp have been taken, and throughout every blank cycle.
- R8: After a fault, BLANK_CYCLES (3) full soft-start periods run with `drv_en` 0 and `fault` 1. Each period is INIT_TICKS ticks at code 0 followed by STEP_COUNT-1 increments. The completing tick returns the code to 0 rather than holding the final value.
- R9: The tick that completes the third blank period starts the real period. `drv_en` becomes 1 and `fault` becomes 0 with `ref_code` at 0. If the undervoltage is still present after that ramp is unmasked, the hiccup repeats without limit.
- R10: While the shutdown request is held, the outputs stay off and step ticks have no effect. Releasing it begins a fresh start as in R3.
- R11: The ready, undervoltage and shutdown inputs pass through two synchronizing flops. An output reacts on the third rising clock edge after one of these inputs changes. `step_tick` is a one-cycle enable that acts on the edge where it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_tick | input | 1 | One-cycle enable for each slow soft-start step |
| rdy_a | input | 1 | First bias supply is above its ready threshold |
| rdy_b | input | 1 | Second bias supply is above its ready threshold |
| uv_a | input | 1 | Channel A feedback is below the undervoltage level |
| uv_b | input | 1 | Channel B feedback is below the undervoltage level |
| shutdown_req | input | 1 | Hold both channels off while high |
| ref_code | output | CODE_W | Shared reference DAC code |
| drv_en | output | 1 | Gate driver enable for both channels |
| ss_done | output | 1 | Reference has reached its final code in a live ramp |
| fault | output | 1 | Undervoltage hiccup in progress |

## Verification
The bench aims at the edges of the unmask window. An undervoltage raised at step six must be ignored and must trip on step seven. A design that unmasks too early would fault spuriously during start-up, and one that never unmasks would miss a collapsed output. A flag raised during a blank cycle must leave the sweep untouched, because a design that re-arms there would stay in hiccup forever. The bench also counts ticks exactly to the boundary between the third blank period and the real one, so an off-by-one blank count shows up as drivers enabled one period early or late. Finally, it checks the two-flop latency and the case where only one ready flag is present, so a missing synchronizer or a single-supply start would be caught.

// File: rtl/ssh_pkg.sv
package ssh_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_INIT = 2'd1,
        ST_RAMP = 2'd2,
        ST_HOLD = 2'd3
    } ssh_state_e;

    typedef struct packed {
        logic sd;
        logic uv_b;
        logic uv_a;
        logic rdy_b;
        logic rdy_a;
    } ssh_inputs_t;

endpackage

// File: rtl/ssh_sync.sv
module ssh_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = d;
        s_d.stab = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.stab;

endmodule

// File: rtl/ssh_ramp.sv
module ssh_ramp #(
    parameter int CODE_W      = 8,
    parameter int STEP_COUNT  = 27,
    parameter int STEP_INC    = 4,
    parameter int UNMASK_STEP = 7,
    localparam int STEP_W     = $clog2(STEP_COUNT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [CODE_W-1:0] code,
    output logic              last_step,
    output logic              unmasked
);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [CODE_W-1:0] code;
    } ramp_t;

    ramp_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.step = '0;
            r_d.code = '0;
        end else if (adv) begin
            r_d.step = r_q.step + STEP_W'(1);
            r_d.code = r_q.code + CODE_W'(STEP_INC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign code      = r_q.code;
    assign last_step = (r_q.step == STEP_W'(STEP_COUNT - 1));
    assign unmasked  = (r_q.step >= STEP_W'(UNMASK_STEP));

endmodule

// File: rtl/ssh_ctrl.sv
module ssh_ctrl
    import ssh_pkg::*;
#(
    parameter int INIT_TICKS   = 3,
    parameter int BLANK_CYCLES = 3,
    localparam int IW          = $clog2(INIT_TICKS + 1),
    localparam int BW          = $clog2(BLANK_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run_ok,
    input  logic uv_any,
    input  logic last_step,
    input  logic unmasked,
    output logic ramp_clr,
    output logic ramp_adv,
    output logic drv_en,
    output logic done,
    output logic fault
);

    typedef struct packed {
        ssh_state_e    state;
        logic [IW-1:0] init_cnt;
        logic [BW-1:0] blank_left;
        logic          fault;
        logic          done;
        logic          en;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  live_cycle;
    logic  uv_live;

    always_comb begin
        c_d        = c_q;
        ramp_clr   = 1'b0;
        ramp_adv   = 1'b0;
        live_cycle = (c_q.blank_left == '0);
        uv_live    = live_cycle && uv_any &&
                     ((c_q.state == ST_RAMP && unmasked) || c_q.state == ST_HOLD);

        if (!run_ok) begin
            c_d.state      = ST_OFF;
            c_d.init_cnt   = '0;
            c_d.blank_left = '0;
            c_d.fault      = 1'b0;
            c_d.done       = 1'b0;
            c_d.en         = 1'b0;
            ramp_clr       = 1'b1;
        end else if (uv_live) begin
            c_d.state      = ST_INIT;
            c_d.init_cnt   = '0;
            c_d.blank_left = BW'(BLANK_CYCLES);
            c_d.fault      = 1'b1;
            c_d.done       = 1'b0;
            c_d.en         = 1'b0;
            ramp_clr       = 1'b1;
        end else begin
            unique case (c_q.state)
                ST_OFF: begin
                    c_d.state    = ST_INIT;
                    c_d.init_cnt = '0;
                    c_d.en       = 1'b1;
                    ramp_clr     = 1'b1;
                end
                ST_INIT: begin
                    if (tick) begin
                        if (c_q.init_cnt == IW'(INIT_TICKS - 1)) begin
                            c_d.state    = ST_RAMP;
                            c_d.init_cnt = '0;
                        end else begin
                            c_d.init_cnt = c_q.init_cnt + IW'(1);
                        end
                    end
                end
                ST_RAMP: begin
                    if (tick) begin
                        if (last_step && !live_cycle) begin
                            ramp_clr       = 1'b1;
                            c_d.state      = ST_INIT;
                            c_d.init_cnt   = '0;
                            c_d.blank_left = c_q.blank_left - BW'(1);
                            if (c_q.blank_left == BW'(1)) begin
                                c_d.fault = 1'b0;
                                c_d.en    = 1'b1;
                            end
                        end else begin
                            ramp_adv = 1'b1;
                            if (last_step) begin
                                c_d.state = ST_HOLD;
                                c_d.done  = 1'b1;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    c_d.state = ST_HOLD;
                end
                default: c_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_OFF;
        end else begin
            c_q <= c_d;
        end
    end

    assign drv_en = c_q.en;
    assign done   = c_q.done;
    assign fault  = c_q.fault;

endmodule

// File: rtl/ssh_top.sv
module ssh_top
    import ssh_pkg::*;
#(
    parameter int CODE_W       = 8,
    parameter int STEP_COUNT   = 27,
    parameter int STEP_INC     = 4,
    parameter int INIT_TICKS   = 3,
    parameter int UNMASK_STEP  = 7,
    parameter int BLANK_CYCLES = 3,
    localparam int FINAL_CODE  = STEP_COUNT * STEP_INC,
    localparam int IN_W        = $bits(ssh_inputs_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_tick,
    input  logic              rdy_a,
    input  logic              rdy_b,
    input  logic              uv_a,
    input  logic              uv_b,
    input  logic              shutdown_req,
    output logic [CODE_W-1:0] ref_code,
    output logic              drv_en,
    output logic              ss_done,
    output logic              fault
);

    ssh_inputs_t raw_in, syn_in;
    logic [IN_W-1:0] syn_vec;
    logic run_ok, uv_any;
    logic ramp_clr, ramp_adv, last_step, unmasked;

    always_comb begin
        raw_in.sd    = shutdown_req;
        raw_in.uv_b  = uv_b;
        raw_in.uv_a  = uv_a;
        raw_in.rdy_b = rdy_b;
        raw_in.rdy_a = rdy_a;
    end

    ssh_sync #(.W(IN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_vec)
    );

    assign syn_in = ssh_inputs_t'(syn_vec);
    assign run_ok = syn_in.rdy_a & syn_in.rdy_b & ~syn_in.sd;
    assign uv_any = syn_in.uv_a | syn_in.uv_b;

    ssh_ctrl #(
        .INIT_TICKS   (INIT_TICKS),
        .BLANK_CYCLES (BLANK_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (step_tick),
        .run_ok    (run_ok),
        .uv_any    (uv_any),
        .last_step (last_step),
        .unmasked  (unmasked),
        .ramp_clr  (ramp_clr),
        .ramp_adv  (ramp_adv),
        .drv_en    (drv_en),
        .done      (ss_done),
        .fault     (fault)
    );

    ssh_ramp #(
        .CODE_W      (CODE_W),
        .STEP_COUNT  (STEP_COUNT),
        .STEP_INC    (STEP_INC),
        .UNMASK_STEP (UNMASK_STEP)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ramp_clr),
        .adv       (ramp_adv),
        .code      (ref_code),
        .last_step (last_step),
        .unmasked  (unmasked)
    );

endmodule

// File: rtl/ssh_chk.sv
module ssh_chk #(
    parameter int CODE_W     = 8,
    parameter int FINAL_CODE = 108,
    parameter int STEP_INC   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code,
    input logic              drv_en,
    input logic              done,
    input logic              fault,
    input logic              run_ok,
    input logic              uv_any
);

    a_r2_off_without_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> (!drv_en && code == '0 && !done && !fault));

    a_r4_code_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        code <= CODE_W'(FINAL_CODE));

    a_r4_code_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |-> (code == '0 || code == CODE_W'($past(code) + STEP_INC)));

    a_r5_done_at_final: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (code == CODE_W'(FINAL_CODE) && drv_en));

    a_r6_uv_trips_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && uv_any && done) |=> (fault && !drv_en && code == '0));

    a_r8_fault_drivers_off: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !drv_en);

    a_r9_fault_clear_enables: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fault) && $past(run_ok) && run_ok) |-> (drv_en && code == '0));

endmodule

bind ssh_top ssh_chk #(
    .CODE_W     (CODE_W),
    .FINAL_CODE (FINAL_CODE),
    .STEP_INC   (STEP_INC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .code   (ref_code),
    .drv_en (drv_en),
    .done   (ss_done),
    .fault  (fault),
    .run_ok (run_ok),
    .uv_any (uv_any)
);

// File: tb/ssh_top_test.sv
module ssh_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 8;
    localparam int FINAL      = 108;
    localparam int CYCLE_TICKS = 30;   // init ticks plus ramp steps
    localparam int VEC_N      = 7;
    // {ticks to apply, expected code, expected drv_en, expected ss_done}
    localparam int VEC [VEC_N][4] = '{
        '{2, 0,   1, 0},
        '{1, 0,   1, 0},
        '{1, 4,   1, 0},
        '{5, 24,  1, 0},
        '{20, 104, 1, 0},
        '{1, 108, 1, 1},
        '{3, 108, 1, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_tick = 1'b0;
    logic rdy_a = 1'b0, rdy_b = 1'b0, uv_a = 1'b0, uv_b = 1'b0, shutdown_req = 1'b0;
    logic [CODE_W-1:0] ref_code;
    logic drv_en, ss_done, fault;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssh_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_tick    (step_tick),
        .rdy_a        (rdy_a),
        .rdy_b        (rdy_b),
        .uv_a         (uv_a),
        .uv_b         (uv_b),
        .shutdown_req (shutdown_req),
        .ref_code     (ref_code),
        .drv_en       (drv_en),
        .ss_done      (ss_done),
        .fault        (fault)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic outs(input string req, input int c, input int e, input int d, input int f);
        check({req, " ref_code"}, int'(ref_code), c);
        check({req, " drv_en"},   int'(drv_en),   e);
        check({req, " ss_done"},  int'(ss_done),  d);
        check({req, " fault"},    int'(fault),    f);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_tick = 1'b1;
            @(negedge clk);
            step_tick = 1'b0;
        end
    endtask

    initial begin
        wait_cyc(3);
        outs("R1 reset", 0, 0, 0, 0);
        rst_n = 1'b1;

        // R2: one ready flag alone never starts the block
        rdy_a = 1'b1;
        wait_cyc(4);
        ticks(5);
        outs("R2 single ready", 0, 0, 0, 0);

        // R3, R11: start once the second flag arrives
        rdy_b = 1'b1;
        wait_cyc(4);
        outs("R3 start init", 0, 1, 0, 0);

        // R3, R4, R5: table of ramp steps
        for (int v = 0; v < VEC_N; v++) begin
            ticks(VEC[v][0]);
            check("R4 ramp code", int'(ref_code), VEC[v][1]);
            check("R3 ramp drv_en", int'(drv_en), VEC[v][2]);
            check("R5 ramp done", int'(ss_done), VEC[v][3]);
        end

        // R6: undervoltage while done
        uv_a = 1'b1;
        wait_cyc(3);
        outs("R6 uv trip", 0, 0, 0, 1);
        uv_a = 1'b0;

        // R8: blank sweep with drivers off
        ticks(13);
        outs("R8 blank sweep", 40, 0, 0, 1);

        // R7: undervoltage inside a blank cycle leaves the sweep alone
        uv_a = 1'b1;
        wait_cyc(4);
        outs("R7 blank ignore", 40, 0, 0, 1);
        uv_a = 1'b0;
        wait_cyc(3);

        // R8, R9: boundary between third blank cycle and the real one
        ticks(3 * CYCLE_TICKS - 1 - 13);
        outs("R8 last blank step", 104, 0, 0, 1);
        ticks(1);
        outs("R9 real cycle", 0, 1, 0, 0);

        // R7: masked before the unmask step, trips at it
        ticks(3 + 6);
        uv_b = 1'b1;
        wait_cyc(4);
        outs("R7 masked early", 24, 1, 0, 0);
        ticks(1);
        check("R7 step7 code", int'(ref_code), 28);
        wait_cyc(1);
        outs("R6 unmasked trip", 0, 0, 0, 1);

        // R9: persistent fault keeps the hiccup going
        ticks(3 * CYCLE_TICKS);
        outs("R9 repeat real", 0, 1, 0, 0);
        ticks(3 + 7);
        wait_cyc(1);
        outs("R9 repeat trip", 0, 0, 0, 1);
        uv_b = 1'b0;
        wait_cyc(3);
        ticks(3 * CYCLE_TICKS);
        outs("R9 recover", 0, 1, 0, 0);
        ticks(CYCLE_TICKS);
        outs("R5 recovered done", FINAL, 1, 1, 0);

        // R2: losing a ready flag clears a fault
        uv_a = 1'b1;
        wait_cyc(3);
        check("R6 second trip", int'(fault), 1);
        uv_a = 1'b0;
        rdy_b = 1'b0;
        wait_cyc(3);
        outs("R2 ready lost", 0, 0, 0, 0);

        // R11: exact latency of a ready rise
        rdy_b = 1'b1;
        wait_cyc(2);
        check("R11 latency two", int'(drv_en), 0);
        wait_cyc(1);
        check("R11 latency three", int'(drv_en), 1);
        ticks(CYCLE_TICKS);
        outs("R5 done again", FINAL, 1, 1, 0);

        // R10: shutdown held, then released
        shutdown_req = 1'b1;
        wait_cyc(3);
        outs("R10 shutdown", 0, 0, 0, 0);
        ticks(5);
        outs("R10 ticks ignored", 0, 0, 0, 0);
        shutdown_req = 1'b0;
        wait_cyc(3);
        outs("R10 released", 0, 1, 0, 0);
        ticks(3 + 2);
        outs("R10 fresh ramp", 8, 1, 0, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule